// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides a fast input clock into a slower output clock. The lengths of the low and high parts of the output period are set by two separate 4-bit count fields, so both the period and the duty cycle can be programmed. Three byte-wide configuration registers are loaded through a simple write port. They hold the two count fields and a set of control bits: pass-through of the input clock, response to a chip-level synchronisation input, a forced static level, the level the output starts at, a restart phase delay, duty-cycle balancing and channel power-down.

The divider is a Moore state machine with six states. `ST_OFF` holds the output low while the channel is powered down or bypassed. `ST_FORCE` holds a static level. `ST_HOLD` waits at the start level while synchronisation is obeyed and asserted. `ST_PHASE` delays the first edge after release. `ST_HIGH` and `ST_LOW` count the two parts of the period.

The transitions, with priority from the top down:
- Any state goes to `ST_OFF` on power-down or bypass.
- Any state goes to `ST_FORCE` when force is set together with ignore-sync.
- Any state goes to `ST_HOLD` when sync is asserted and obeyed.
- Otherwise:
  - `ST_OFF` and `ST_FORCE` go to `ST_HOLD`.
  - `ST_HOLD` goes to `ST_PHASE`, or straight to the start state when the offset is zero.
  - `ST_PHASE` goes to the start state after the offset count.
  - `ST_HIGH` and `ST_LOW` alternate when their counts expire.

Reset enters `ST_HOLD`. Several such channels are expected to share one sync line, so that their outputs restart aligned.

Top module: `clkdiv_channel`

## Requirements
- R1: Reset sets the count register to 0x77 and every other control bit to 0. After reset, and after a sync release with these defaults, the output is low for 8 input cycles and then high for 8, repeating.
- R2: With balancing disabled, or with an even total period, the output is high for H+1 and low for L+1 input cycles. H is the high-count field and L is the low-count field, each from 0 to 15.
- R3: With bypass set and power-down clear, the output equals the input clock: low in the low half and high in the high half. The force bit has no effect in this mode.
- R4: While sync is asserted and ignore-sync is clear, the output holds the start level and the counters are cleared.
- R5: With ignore-sync set, asserting sync leaves the running output pattern unchanged.
- R6: With force and ignore-sync both set, the output is static at the start-high bit's value. With force set and ignore-sync clear, force has no effect.
- R7: After sync is sampled low at edge e0, the output sits at the start level: high when the start-high bit is 1, low when it is 0. The first part of the period counted from e0 is the part of that level.
- R8: A nonzero phase offset P delays the first transition after release by P input cycles. The start level therefore lasts P plus its normal part length.
- R9: With balancing enabled and N = (L+1)+(H+1) odd, the high part lasts (N+1)/2 cycles and the low part lasts (N-1)/2.
- R10: With power-down set, the output is low whatever bypass, force and sync say, and the state machine is in `ST_OFF` one cycle later.
- R11: Register map, written on a rising edge with wr_en high:
  - Address 0: bits 7:4 are the low count, bits 3:0 the high count.
  - Address 1: bit 7 is bypass, bit 6 ignore-sync, bit 5 force, bit 4 start-high, bits 3:0 the phase offset.
  - Address 2: bit 1 is power-down, bit 0 disables balancing.
  - Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low reset, synchronous release |
| sync_in | input | 1 | Chip-level synchronisation, sampled on clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| clk_out | output | 1 | Divided (or passed-through) output clock |

## Verification
The assertions check these on every cycle:
- An obeyed sync forces `ST_HOLD`.
- Force with ignore-sync forces `ST_FORCE`.
- Power-down reaches `ST_OFF`.
- Leaving `ST_HOLD` with zero offset picks the state that matches the start-high bit.
- `ST_PHASE` is entered only with a nonzero offset.

The exact part lengths, the balancing arithmetic, the phase delay in cycles, the pass-through clock and the immunity to an ignored sync are shown only by the bench scenarios. Those scenarios compare every output sample against a pattern computed from the requirements.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    // Width of each count field and of the phase offset
    localparam int unsigned FIELD_W = 4;
    // Part length can reach 2**FIELD_W, so one extra bit
    localparam int unsigned LEN_W   = FIELD_W + 1;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned DATA_W  = 8;

    localparam logic [ADDR_W-1:0] ADDR_COUNTS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PWR    = 2'd2;

    localparam logic [FIELD_W-1:0] COUNT_RST = 4'd7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_PHASE,
        ST_HIGH,
        ST_LOW,
        ST_FORCE
    } div_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] low_cnt;
        logic [FIELD_W-1:0] high_cnt;
        logic               bypass;
        logic               ign_sync;
        logic               force_lvl;
        logic               start_high;
        logic [FIELD_W-1:0] phase;
        logic               pwr_down;
        logic               dcc_off;
    } div_cfg_t;
endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output div_cfg_t          cfg
);
    // R11: byte map; address 3 decodes to nothing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.low_cnt    <= COUNT_RST;
            cfg.high_cnt   <= COUNT_RST;
            cfg.bypass     <= 1'b0;
            cfg.ign_sync   <= 1'b0;
            cfg.force_lvl  <= 1'b0;
            cfg.start_high <= 1'b0;
            cfg.phase      <= '0;
            cfg.pwr_down   <= 1'b0;
            cfg.dcc_off    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_COUNTS: begin
                    cfg.low_cnt  <= wr_data[7:4];
                    cfg.high_cnt <= wr_data[3:0];
                end
                ADDR_CTRL: begin
                    cfg.bypass     <= wr_data[7];
                    cfg.ign_sync   <= wr_data[6];
                    cfg.force_lvl  <= wr_data[5];
                    cfg.start_high <= wr_data[4];
                    cfg.phase      <= wr_data[3:0];
                end
                ADDR_PWR: begin
                    cfg.pwr_down <= wr_data[1];
                    cfg.dcc_off  <= wr_data[0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clkdiv_len_calc.sv
module clkdiv_len_calc
    import clkdiv_pkg::*;
(
    input  logic [FIELD_W-1:0] low_cnt,
    input  logic [FIELD_W-1:0] high_cnt,
    input  logic               dcc_off,
    output logic [LEN_W-1:0]   hi_len,
    output logic [LEN_W-1:0]   lo_len
);
    localparam int unsigned SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] half_up;
    logic [SUM_W-1:0] half_dn;

    always_comb begin
        total   = SUM_W'(low_cnt) + SUM_W'(high_cnt) + SUM_W'(2);
        half_up = (total + SUM_W'(1)) >> 1;
        half_dn = total - half_up;
        // R9: balance an odd period; R2: otherwise use the fields as written
        if (!dcc_off && total[0]) begin
            hi_len = half_up[LEN_W-1:0];
            lo_len = half_dn[LEN_W-1:0];
        end else begin
            hi_len = LEN_W'(high_cnt) + LEN_W'(1);
            lo_len = LEN_W'(low_cnt) + LEN_W'(1);
        end
    end
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  div_cfg_t         cfg,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] lo_len,
    output logic             level,
    output div_state_e       state
);
    div_state_e       state_q, state_d;
    div_state_e       start_state;
    logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             off_req, force_req, hold_req;

    assign off_req     = cfg.pwr_down | cfg.bypass;          // R3, R10
    assign force_req   = cfg.force_lvl & cfg.ign_sync;       // R6
    assign hold_req    = sync_in & ~cfg.ign_sync;            // R4, R5
    assign start_state = cfg.start_high ? ST_HIGH : ST_LOW;  // R7
    assign cnt_inc     = cnt_q + LEN_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (off_req) begin
            state_d = ST_OFF;
        end else if (force_req) begin
            state_d = ST_FORCE;
        end else if (hold_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_OFF, ST_FORCE: state_d = ST_HOLD;
                ST_HOLD:  state_d = (cfg.phase != '0) ? ST_PHASE : start_state;
                ST_PHASE: if (cnt_inc >= LEN_W'(cfg.phase)) state_d = start_state; // R8
                ST_HIGH:  if (cnt_inc >= hi_len) state_d = ST_LOW;
                ST_LOW:   if (cnt_inc >= lo_len) state_d = ST_HIGH;
                default:  state_d = ST_HOLD;
            endcase
        end
        if (state_d != state_q || state_q == ST_OFF || state_q == ST_HOLD ||
            state_q == ST_FORCE) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_inc;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_HIGH:                     level = 1'b1;
            ST_LOW, ST_OFF:              level = 1'b0;
            ST_HOLD, ST_PHASE, ST_FORCE: level = cfg.start_high;
            default:                     level = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clk_out
);
    div_cfg_t         cfg;
    logic [LEN_W-1:0] hi_len, lo_len;
    logic             div_level;
    div_state_e       fsm_state;

    clkdiv_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    clkdiv_len_calc u_len (
        .low_cnt  (cfg.low_cnt),
        .high_cnt (cfg.high_cnt),
        .dcc_off  (cfg.dcc_off),
        .hi_len   (hi_len),
        .lo_len   (lo_len)
    );

    clkdiv_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .cfg     (cfg),
        .hi_len  (hi_len),
        .lo_len  (lo_len),
        .level   (div_level),
        .state   (fsm_state)
    );

    // R10 power-down wins; R3 bypass passes the input clock through
    assign clk_out = cfg.pwr_down ? 1'b0 : (cfg.bypass ? clk : div_level);
endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk
    import clkdiv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sync_in,
    input div_cfg_t   cfg,
    input div_state_e fsm_state
);
    logic off_c, force_c, obey_c;
    assign off_c   = cfg.pwr_down | cfg.bypass;
    assign force_c = cfg.force_lvl & cfg.ign_sync;
    assign obey_c  = sync_in & ~cfg.ign_sync;

    a_r4_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (obey_c && !off_c) |=> (fsm_state == ST_HOLD));

    a_r6_force_static: assert property (@(posedge clk) disable iff (!rst_n)
        (force_c && !off_c) |=> (fsm_state == ST_FORCE));

    a_r10_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.pwr_down |=> (fsm_state == ST_OFF));

    a_r7_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOLD && !obey_c && !off_c && !force_c && cfg.phase == '0)
        |=> (fsm_state == ($past(cfg.start_high) ? ST_HIGH : ST_LOW)));

    a_r8_phase_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == ST_HOLD && fsm_state == ST_PHASE) |-> ($past(cfg.phase) != '0));
endmodule

bind clkdiv_channel clkdiv_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .cfg       (cfg),
    .fsm_state (fsm_state)
);

// File: tb/sim_clkdiv_channel.sv
module sim_clkdiv_channel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       clk_out;

    int errors = 0;
    int checks = 0;

    bit    exp_q[$];
    string tag_q[$];

    clkdiv_channel u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_out (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: clk_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected sample per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), clk_out, exp_q.pop_front());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) tick();
        tick();
    endtask

    function automatic bit exp_lvl(int k, bit st, int p, int hi, int lo);
        int first  = st ? hi : lo;
        int second = st ? lo : hi;
        int r;
        if (k < p + first) return st;
        r = (k - p - first) % (hi + lo);
        return (r < second) ? !st : st;
    endfunction

    // Driver: holds sync, pushes hold samples then the computed pattern, releases sync
    task automatic aligned_run(string tag, bit st, int p, int hi, int lo, int hold, int n);
        sync_in = 1'b1;
        repeat (3) tick();
        for (int i = 0; i < hold; i++) begin
            exp_q.push_back(st);
            tag_q.push_back("R4");
        end
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp_lvl(k, st, p, hi, lo));
            tag_q.push_back(tag);
        end
        repeat (hold - 1) tick();
        sync_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state: held in hold at start level low
        repeat (3) @(negedge clk);
        check("R1", clk_out, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();

        // R1 defaults 8 low / 8 high, R4 hold
        aligned_run("R1", 1'b0, 0, 8, 8, 3, 40);
        drain();

        // R2 independent lengths, balancing off
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h25);
        aligned_run("R2", 1'b0, 0, 6, 3, 1, 30);
        drain();
        wr(2'd0, 8'h00);
        aligned_run("R2", 1'b0, 0, 1, 1, 1, 12);
        drain();
        wr(2'd0, 8'hFF);
        aligned_run("R2", 1'b0, 0, 16, 16, 2, 40);
        drain();

        // R9 odd period balanced, start high (R7)
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h41);
        wr(2'd1, 8'h10);
        aligned_run("R9", 1'b1, 0, 4, 3, 1, 30);
        drain();
        wr(2'd2, 8'h01);
        aligned_run("R7", 1'b1, 0, 2, 5, 1, 30);
        drain();

        // R8 phase offset
        wr(2'd0, 8'h32);
        wr(2'd1, 8'h05);
        aligned_run("R8", 1'b0, 5, 3, 4, 1, 30);
        drain();
        wr(2'd1, 8'h1F);
        aligned_run("R8", 1'b1, 15, 3, 4, 1, 40);
        drain();

        // R6 force without ignore-sync has no effect
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h30);
        aligned_run("R6", 1'b1, 0, 2, 2, 1, 20);
        drain();

        // R5 ignored sync, R11 address 3 ignored
        wr(2'd0, 8'h22);
        wr(2'd1, 8'h00);
        aligned_run("R5,R11", 1'b0, 0, 3, 3, 1, 60);
        repeat (8) tick();
        wr(2'd1, 8'h40);
        wr(2'd3, 8'hFF);
        repeat (3) tick();
        sync_in = 1'b1;
        repeat (5) tick();
        sync_in = 1'b0;
        drain();

        // R6 force active: static at start-high value
        wr(2'd1, 8'h70);
        repeat (3) tick();
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(1'b1);
            tag_q.push_back("R6");
        end
        drain();
        wr(2'd1, 8'h60);
        repeat (3) tick();
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(1'b0);
            tag_q.push_back("R6");
        end
        drain();

        // R3 bypass passes the clock, force ignored
        wr(2'd1, 8'hF0);
        repeat (3) tick();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            check("R3", clk_out, 1'b0);
            @(posedge clk);
            #(CLK_PERIOD/4);
            check("R3", clk_out, 1'b1);
        end

        // R10 power-down overrides bypass and divider
        wr(2'd2, 8'h02);
        repeat (2) tick();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            check("R10", clk_out, 1'b0);
            @(posedge clk);
            #(CLK_PERIOD/4);
            check("R10", clk_out, 1'b0);
        end
        wr(2'd1, 8'h10);
        sync_in = 1'b0;
        repeat (3) tick();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            check("R10", clk_out, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule